// File: doc/BRIEF.md
# Gated Two-Phase Clock Generator

This block derives a pair of processor clocks from a free-running base clock using only logic clocked by that base clock. Each generated cycle has two parts. `clk_ph1` is high for one base cycle, and `clk_ph2` is high for the base cycle right after it. The two outputs are therefore a pulse and its opposite-phase companion. They are never high together.

A programmable gap count slows the generated clocks down. It does this by holding both outputs low for that many base cycles between successive cycles, not by stretching each phase. A hold input freezes both outputs low. While the block is frozen, each rising edge on a step input releases exactly one complete cycle. Reset suppresses every pulse.

The step input is synchronised and edge-detected inside the block. A step edge that arrives while a stepped cycle is still running is remembered and delivered once that cycle is over. A step edge that arrives while the clocks are running freely is dropped.

When hold is removed, the block always begins with a full gap period before the next pulse. The first pulse after reset behaves the same way, so no pulse is ever cut short.

Top module: `twophase_clkgen`

## Requirements
- R1: `gap_limit` is 20 bits wide. Bit 0 is ignored, so the gap in effect is G = `gap_limit` with bit 0 forced to 0. An odd value therefore behaves exactly like the even value just below it.
- R2: With G = 0 and hold low, `clk_ph1` is high on every second base cycle. `clk_ph2` is high on each of the other base cycles.
- R3: With G > 0 and hold low, successive `clk_ph1` pulses are G+2 base cycles apart. Each pulse is one base cycle long. `clk_ph2` is high only in the base cycle right after each `clk_ph1` pulse. Both outputs are low for the G cycles in between.
- R4: `clk_ph1` and `clk_ph2` are never high in the same base cycle. Every `clk_ph1` high cycle is followed at once by a `clk_ph2` high cycle.
- R5: When hold is raised, a cycle already in progress finishes, including its `clk_ph2` half. After that, both outputs stay low for as long as hold is high and no step edge arrives.
- R6: While hold is high, each rising edge of the step input produces exactly one `clk_ph1` pulse and one `clk_ph2` pulse. The step input must stay high for at least two base cycles.
- R7: A step edge that is detected while a stepped cycle is still running is queued. It yields its own complete cycle after the running one ends.
- R8: Step edges that arrive while hold is low are discarded. They produce no pulse once hold is raised later.
- R9: When hold is sampled low after a hold, the first `clk_ph1` pulse appears after the (G+1)-th rising base edge counted from the edge that sampled hold low. Before it there is a full gap of G cycles.
- R10: While `rst_n` is low, both outputs are low. After `rst_n` rises with hold low, the first `clk_ph1` pulse follows the (G+1)-th rising base edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Free-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Freeze both generated clocks, synchronous to clk_base |
| step_req | input | 1 | Single-step request, may be asynchronous |
| gap_limit | input | 20 | Low-gap length in base cycles; bit 0 ignored |
| clk_ph1 | output | 1 | Generated clock, first phase |
| clk_ph2 | output | 1 | Generated clock, opposite phase |

## Verification
The assertions take `hold_req` and `gap_limit` to be synchronous to the base clock. They also take `gap_limit` to change only while reset is asserted, and step pulses to be long enough to pass the two-stage synchroniser. The stimulus changes inputs only on falling base edges. It alters the gap value only inside a reset window, and it keeps every step high for two or more cycles, with at least one low cycle between steps. Odd gap values are applied on purpose, to show that the low bit has no effect.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Sequencer states: parked (held or just reset), gap, high phase, low phase
  typedef enum logic [1:0] {
    ST_PARK = 2'd0,
    ST_GAP  = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/clkgen_step_sync.sv
module clkgen_step_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic hold,
  input  logic take,
  output logic pend_o,
  output logic edge_o
);

  localparam int SHW = SYNC_STAGES + 1;

  logic [SHW-1:0] sh_q;
  logic           pend_q;
  logic           step_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SHW-2:0], step_in};
  end

  assign step_edge = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // One pending step; discarded whenever the clocks run free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (!hold) pend_q <= 1'b0;
    else            pend_q <= (pend_q & ~take) | step_edge;
  end

  assign pend_o = pend_q;
  assign edge_o = step_edge;

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> !pend_o);

  // R6
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !step_edge && hold) |=> !pend_o);

endmodule

// File: rtl/clkgen_gap_timer.sv
module clkgen_gap_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q <= CW'(1));

  // R3
  gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val >= CW'(2)) |=> !expire);

endmodule

// File: rtl/clkgen_phase_seq.sv
module clkgen_phase_seq
  import clkgen_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          pend,
  input  logic [CW-1:0] gap_val,
  input  logic          expire,
  output logic          load,
  output logic          take,
  output logic          ph1,
  output logic          ph2
);

  seq_state_t state_q, nxt;
  logic       gap_zero;
  logic       pulse_start;
  logic       ph1_q, ph2_q;

  assign gap_zero = (gap_val == '0);

  always_comb begin
    nxt  = state_q;
    load = 1'b0;
    take = 1'b0;
    unique case (state_q)
      ST_PARK: begin
        if (!hold) begin
          if (gap_zero) nxt = ST_HI;
          else begin nxt = ST_GAP; load = 1'b1; end
        end else if (pend) begin
          nxt  = ST_HI;
          take = 1'b1;
        end
      end
      ST_HI: nxt = ST_LO;
      ST_LO: begin
        if (hold)          nxt = ST_PARK;
        else if (gap_zero) nxt = ST_HI;
        else begin nxt = ST_GAP; load = 1'b1; end
      end
      ST_GAP: begin
        if (hold)        nxt = ST_PARK;
        else if (expire) nxt = ST_HI;
      end
      default: nxt = ST_PARK;
    endcase
  end

  assign pulse_start = (nxt == ST_HI) && (state_q != ST_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PARK;
      ph1_q   <= 1'b0;
      ph2_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      ph1_q   <= pulse_start;
      ph2_q   <= (nxt == ST_LO);
    end
  end

  assign ph1 = ph1_q;
  assign ph2 = ph2_q;

  // R4
  ph_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_q && ph2_q));

  // R4
  ph2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_q |=> (ph2_q && !ph1_q));

  // R5
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK && hold && !pend) |=> (!ph1_q && !ph2_q));

  // R3
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && !expire) |=> !ph1_q);

  // R10
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!ph1_q && !ph2_q);
  end

endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int LIMIT_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_base,
  input  logic               rst_n,
  input  logic               hold_req,
  input  logic               step_req,
  input  logic [LIMIT_W-1:0] gap_limit,
  output logic               clk_ph1,
  output logic               clk_ph2
);

  // Effective gap: the low bit carries no weight
  function automatic logic [LIMIT_W-1:0] even_gap(input logic [LIMIT_W-1:0] lim);
    return {lim[LIMIT_W-1:1], 1'b0};
  endfunction

  logic [LIMIT_W-1:0] gap_eff;
  logic               step_pend;
  logic               step_edge;
  logic               step_take;
  logic               gap_load;
  logic               gap_expire;

  assign gap_eff = even_gap(gap_limit);

  clkgen_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk     (clk_base),
    .rst_n   (rst_n),
    .step_in (step_req),
    .hold    (hold_req),
    .take    (step_take),
    .pend_o  (step_pend),
    .edge_o  (step_edge)
  );

  clkgen_gap_timer #(.CW(LIMIT_W)) u_gap (
    .clk      (clk_base),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_eff),
    .expire   (gap_expire)
  );

  clkgen_phase_seq #(.CW(LIMIT_W)) u_seq (
    .clk     (clk_base),
    .rst_n   (rst_n),
    .hold    (hold_req),
    .pend    (step_pend),
    .gap_val (gap_eff),
    .expire  (gap_expire),
    .load    (gap_load),
    .take    (step_take),
    .ph1     (clk_ph1),
    .ph2     (clk_ph2)
  );

  // R1
  low_bit_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    gap_load |-> !gap_eff[0]);

  // R7
  queued_step_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    (step_edge && hold_req && clk_ph1) |=> step_pend);

endmodule

// File: tb/test_twophase_clkgen.sv
`timescale 1ns/1ps
module test_twophase_clkgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_req = 1'b0;
  logic        step_req = 1'b0;
  logic [19:0] gap_limit = '0;
  logic        clk_ph1, clk_ph2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twophase_clkgen i_twophase_clkgen (
    .clk_base  (clk),
    .rst_n     (rst_n),
    .hold_req  (hold_req),
    .step_req  (step_req),
    .gap_limit (gap_limit),
    .clk_ph1   (clk_ph1),
    .clk_ph2   (clk_ph2)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ph1(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!clk_ph1 && k < 300);
  endtask

  task automatic window(input int n, output int p1, output int p2);
    p1 = 0; p2 = 0;
    repeat (n) begin
      @(negedge clk);
      p1 += int'(clk_ph1);
      p2 += int'(clk_ph2);
    end
  endtask

  initial begin
    int gaps[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 14, 64};
    for (int gi = 0; gi < 12; gi++) begin
      int g, ge, k, p1, p2, quiet;
      string tag;
      g  = gaps[gi];
      ge = g & ~1;
      tag = (g == 0) ? "R2" : ((g % 2) ? "R1" : "R3");

      // R10: quiet while in reset
      @(negedge clk);
      rst_n = 1'b0; hold_req = 1'b0; step_req = 1'b0;
      gap_limit = 20'(g);
      quiet = 0;
      repeat (4) begin
        @(negedge clk);
        quiet += int'(clk_ph1) + int'(clk_ph2);
      end
      chk(quiet == 0, "R10 reset quiet", quiet, 0);

      // R10: first pulse after reset release
      rst_n = 1'b1;
      wait_ph1(k);
      chk(k == ge + 1, "R10 first pulse", k, ge + 1);

      // R1/R2/R3 with R4: three full periods
      for (int p = 0; p < 3; p++) begin
        bit ok;
        int bad;
        ok = 1'b1; bad = 0;
        for (int j = 1; j <= ge + 2; j++) begin
          @(negedge clk);
          if (clk_ph1 != (j == ge + 2) || clk_ph2 != (j == 1)) begin
            if (ok) bad = j;
            ok = 1'b0;
          end
        end
        chk(ok, {tag, " R4 period"}, bad, 0);
      end

      // R5: hold raised during a high phase
      hold_req = 1'b1;
      window(40, p1, p2);
      chk(p1 == 0 && p2 == 1, "R5 hold ph1", p1, 0);
      chk(p2 == 1, "R5 hold ph2", p2, 1);

      // R6: two single steps
      for (int s = 0; s < 2; s++) begin
        fork
          begin
            step_req = 1'b1;
            repeat (3) @(negedge clk);
            step_req = 1'b0;
          end
          window(14, p1, p2);
        join
        chk(p1 == 1 && p2 == 1, "R6 step ph1", p1, 1);
      end

      // R7: second edge lands while the stepped cycle runs
      fork
        begin
          step_req = 1'b1;
          repeat (2) @(negedge clk);
          step_req = 1'b0;
          @(negedge clk);
          step_req = 1'b1;
          repeat (2) @(negedge clk);
          step_req = 1'b0;
        end
        window(20, p1, p2);
      join
      chk(p1 == 2 && p2 == 2, "R7 queued steps", p1, 2);

      // R9: release from hold
      hold_req = 1'b0;
      wait_ph1(k);
      chk(k == ge + 1, "R9 release", k, ge + 1);

      // R8: step while running is dropped
      step_req = 1'b1;
      repeat (3) @(negedge clk);
      step_req = 1'b0;
      repeat (10) @(negedge clk);
      wait_ph1(k);
      hold_req = 1'b1;
      window(40, p1, p2);
      chk(p1 == 0 && p2 == 1, "R8 dropped step", p1, 0);

      // R10: reset in the middle of operation
      hold_req = 1'b0;
      repeat (ge + 3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!clk_ph1 && !clk_ph2, "R10 async reset", int'(clk_ph1) + int'(clk_ph2), 0);
      window(3, p1, p2);
      chk(p1 + p2 == 0, "R10 held in reset", p1 + p2, 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule